// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a parameterised number of external interrupt pins, qualifies each one, and merges them into one interrupt request for a processor. Each line passes through a two-flop synchroniser. It can then be set to respond to a level or to an edge, of either polarity. An edge is held in a latch until software acknowledges it. Software can also raise any line itself through a trigger bit that stays set until it is cleared. Each line has a mask and a domain-enable bit, and both gate what the line reports.

Software reaches the controller over a simple single-cycle register bus. The address is split into a window index (bits 11:6, windows 0x40 bytes apart) and a word index (bits 5:2). Line n sits at bit n%32 of word n/32 in every window. Most control fields have three windows: a read view, a set alias and a clear alias. A write to an alias changes only the bit positions written as 1, so a driver never needs a read-modify-write cycle.

Top module: `xl_intc`

## Requirements
- R1: After a synchronous reset every mask bit reads 1, and the sensitivity, polarity, software-trigger, domain-enable and status words read 0, with `irq_o` low.
- R2: The set windows (mask 0x0C0, sensitivity 0x180, trigger 0x240, polarity 0x340) set only the bits written as 1, and the clear windows (0x100, 0x1C0, 0x280, 0x380) clear only the bits written as 1. Writes to the read views (mask 0x080, sensitivity 0x140, trigger 0x200, polarity 0x300) are ignored. The domain-enable word at 0x400 is written whole. Bits above the last line read 0, and a write whose address bits 1:0 are not zero is ignored.
- R3: A line whose mask bit is 1 reports no status, whatever its latch, level or trigger state.
- R4: With sensitivity bit 0 (edge mode), a synchronised transition into the selected polarity sets the line's latch. Polarity 1 selects a rising transition and polarity 0 a falling one. The status bit appears at the third rising clock edge after the pin changes, and it stays set after the pin returns.
- R5: With sensitivity bit 1 (level mode), the status follows the synchronised pin while the pin equals the polarity bit, and nothing is latched.
- R6: Writing 1 to a bit of the acknowledge window (0x000 + 0x40) clears that line's edge latch. Lines written as 0 keep their latch.
- R7: If an acknowledge and a new edge on the same line fall in the same cycle, the latch stays set.
- R8: A set trigger bit makes the line pending with the pin idle, and it stays pending until the trigger-clear alias is written.
- R9: A line whose domain-enable bit is 0 never reports status.
- R10: The status window at 0x000 returns each line's status at bit n%32 of word n/32, and `irq_o` is high exactly when some status bit is set.
- R11: Lines at index 32 and above are reached in word 1 of each window (address + 4), and they behave the same way as the lines in word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_addr | input | 12 | Byte address: window in bits 11:6, word in bits 5:2 |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_status_o | output | NUM_LINES | Per-line qualified status |
| irq_o | output | 1 | OR of all line status bits |

## Verification
The bench builds the controller with NUM_LINES = 40. This gives a full first word and a second word with only eight live bits. Alias writes, level detection and masking are therefore exercised in word 1 as well as word 0, and the bench can check that the unused upper bits of a partial word stay at zero even after an all-ones write. With forty lines the run stays short, while line indices such as 33 and 39 still land in the second word.

// File: rtl/xl_pkg.sv
// Package: shared window codes and widths of the interrupt line controller.
// Assumes byte addresses of 12 bits: window index in [11:6], word in [5:2].
package xl_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WIN_W   = 6;
    localparam int WORD_W  = 4;

    typedef enum logic [WIN_W-1:0] {
        WIN_STATUS   = 6'd0,
        WIN_ACK      = 6'd1,
        WIN_MASK     = 6'd2,
        WIN_MASK_SET = 6'd3,
        WIN_MASK_CLR = 6'd4,
        WIN_SENS     = 6'd5,
        WIN_SENS_SET = 6'd6,
        WIN_SENS_CLR = 6'd7,
        WIN_SOFT     = 6'd8,
        WIN_SOFT_SET = 6'd9,
        WIN_SOFT_CLR = 6'd10,
        WIN_POL      = 6'd12,
        WIN_POL_SET  = 6'd13,
        WIN_POL_CLR  = 6'd14,
        WIN_DOM      = 6'd16
    } win_e;

    // One decoded bus write, handed to every register bank.
    typedef struct packed {
        logic              en;
        logic [WIN_W-1:0]  win;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] data;
    } bus_wr_t;
endpackage

// File: rtl/xl_sync.sv
// Module: two-flop synchroniser per line, plus one more flop holding the
// previous synchronised value for edge detection.
// Assumes pins are asynchronous to clk; reset drives all stages to 0.
module xl_sync #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    output logic [NUM_LINES-1:0] cur_o,
    output logic [NUM_LINES-1:0] prev_o
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic meta_q, sync_q, prev_q;

        // Shift the pin through metastability, sync and history stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign cur_o[i]  = sync_q;
        assign prev_o[i] = prev_q;
    end
endmodule

// File: rtl/xl_ctrl_bank.sv
// Module: one per-line control field with its read view and either
// set/clear aliases (DIRECT = 0) or a plain whole-word write (DIRECT = 1).
// Assumes the bus write is already decoded into window and word.
module xl_ctrl_bank
    import xl_pkg::*;
#(
    parameter int               NUM_LINES = 64,
    parameter logic             RST_VAL   = 1'b0,
    parameter bit               DIRECT    = 1'b0,
    parameter logic [WIN_W-1:0] VIEW_WIN  = 6'd0,
    parameter logic [WIN_W-1:0] SET_WIN   = 6'd0,
    parameter logic [WIN_W-1:0] CLR_WIN   = 6'd0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  bus_wr_t              wr_i,
    output logic [NUM_LINES-1:0] q_o
);
    logic unused_bank;
    assign unused_bank = ^{wr_i.data, wr_i.win, wr_i.word};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
        localparam int W = i / DATA_W;
        localparam int B = i % DATA_W;
        logic hit;
        assign hit = wr_i.en && (wr_i.word == WORD_W'(W));

        if (DIRECT) begin : g_direct
            // Whole-word write through the view window.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_o[i] <= RST_VAL;
                else if (hit && wr_i.win == VIEW_WIN)
                    q_o[i] <= wr_i.data[B];
            end
        end else begin : g_alias
            // Set and clear aliases act only on bits written as one.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_o[i] <= RST_VAL;
                else if (hit && wr_i.win == SET_WIN && wr_i.data[B])
                    q_o[i] <= 1'b1;
                else if (hit && wr_i.win == CLR_WIN && wr_i.data[B])
                    q_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xl_line_detect.sv
// Module: per-line edge latch, level match and status qualification.
// Assumes cur/prev come from the synchroniser; an acknowledge loses to a
// new edge in the same cycle.
module xl_line_detect
    import xl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] cur_i,
    input  logic [NUM_LINES-1:0] prev_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] sens_i,
    input  logic [NUM_LINES-1:0] pol_i,
    input  logic [NUM_LINES-1:0] soft_i,
    input  logic [NUM_LINES-1:0] dom_i,
    input  bus_wr_t              wr_i,
    output logic [NUM_LINES-1:0] latch_o,
    output logic [NUM_LINES-1:0] status_o
);
    logic unused_det;
    assign unused_det = ^{wr_i.data, wr_i.word};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int W = i / DATA_W;
        localparam int B = i % DATA_W;
        logic active, edge_hit, lvl_hit, ack_hit;

        assign active   = (cur_i[i] == pol_i[i]);
        assign edge_hit = !sens_i[i] && active && (prev_i[i] != pol_i[i]);
        assign lvl_hit  = sens_i[i] && active;
        assign ack_hit  = wr_i.en && wr_i.win == WIN_ACK &&
                          wr_i.word == WORD_W'(W) && wr_i.data[B];

        // Hold a detected edge until acknowledged; a new edge wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                latch_o[i] <= 1'b0;
            else if (edge_hit)
                latch_o[i] <= 1'b1;
            else if (ack_hit)
                latch_o[i] <= 1'b0;
        end

        // Qualify the pending sources with mask and domain enable.
        assign status_o[i] = (latch_o[i] | lvl_hit | soft_i[i]) &
                             ~mask_i[i] & dom_i[i];
    end
endmodule

// File: rtl/xl_intc.sv
// Module: top of the external interrupt line controller. Decodes the
// register bus, holds the control banks, runs detection, muxes reads.
// Assumes single-cycle writes and combinational reads; NUM_LINES <= 512.
module xl_intc
    import xl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] line_status_o,
    output logic                 irq_o
);
    localparam int NUM_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W;
    localparam int PAD_W     = NUM_WORDS * DATA_W;

    bus_wr_t              wr;
    logic [WIN_W-1:0]     win;
    logic [WORD_W-1:0]    word;
    logic [NUM_LINES-1:0] cur, prev;
    logic [NUM_LINES-1:0] mask_q, sens_q, pol_q, soft_q, dom_q, latch_q;
    logic [NUM_LINES-1:0] status;
    logic [PAD_W-1:0]     sel_pad;

    assign win  = bus_addr[ADDR_W-1 -: WIN_W];
    assign word = bus_addr[WORD_W+1:2];

    // Package one aligned write for the banks and the latches.
    always_comb begin
        wr.en   = bus_wr && (bus_addr[1:0] == 2'b00);
        wr.win  = win;
        wr.word = word;
        wr.data = bus_wdata;
    end

    xl_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cur_o(cur), .prev_o(prev)
    );

    xl_ctrl_bank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b1), .DIRECT(1'b0),
        .VIEW_WIN(WIN_MASK), .SET_WIN(WIN_MASK_SET), .CLR_WIN(WIN_MASK_CLR))
    u_mask (.clk(clk), .rst_n(rst_n), .wr_i(wr), .q_o(mask_q));

    xl_ctrl_bank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b0), .DIRECT(1'b0),
        .VIEW_WIN(WIN_SENS), .SET_WIN(WIN_SENS_SET), .CLR_WIN(WIN_SENS_CLR))
    u_sens (.clk(clk), .rst_n(rst_n), .wr_i(wr), .q_o(sens_q));

    xl_ctrl_bank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b0), .DIRECT(1'b0),
        .VIEW_WIN(WIN_SOFT), .SET_WIN(WIN_SOFT_SET), .CLR_WIN(WIN_SOFT_CLR))
    u_soft (.clk(clk), .rst_n(rst_n), .wr_i(wr), .q_o(soft_q));

    xl_ctrl_bank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b0), .DIRECT(1'b0),
        .VIEW_WIN(WIN_POL), .SET_WIN(WIN_POL_SET), .CLR_WIN(WIN_POL_CLR))
    u_pol (.clk(clk), .rst_n(rst_n), .wr_i(wr), .q_o(pol_q));

    xl_ctrl_bank #(.NUM_LINES(NUM_LINES), .RST_VAL(1'b0), .DIRECT(1'b1),
        .VIEW_WIN(WIN_DOM), .SET_WIN(WIN_DOM), .CLR_WIN(WIN_DOM))
    u_dom (.clk(clk), .rst_n(rst_n), .wr_i(wr), .q_o(dom_q));

    xl_line_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
        .mask_i(mask_q), .sens_i(sens_q), .pol_i(pol_q), .soft_i(soft_q),
        .dom_i(dom_q), .wr_i(wr), .latch_o(latch_q), .status_o(status)
    );

    assign line_status_o = status;
    assign irq_o         = |status;

    // Pick the field behind the addressed window, padded to whole words.
    always_comb begin
        sel_pad = '0;
        unique case (win)
            WIN_STATUS: sel_pad[NUM_LINES-1:0] = status;
            WIN_MASK:   sel_pad[NUM_LINES-1:0] = mask_q;
            WIN_SENS:   sel_pad[NUM_LINES-1:0] = sens_q;
            WIN_SOFT:   sel_pad[NUM_LINES-1:0] = soft_q;
            WIN_POL:    sel_pad[NUM_LINES-1:0] = pol_q;
            WIN_DOM:    sel_pad[NUM_LINES-1:0] = dom_q;
            default:    sel_pad = '0;
        endcase
    end

    // Select the addressed word; words past the last line read zero.
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word == WORD_W'(w))
                bus_rdata = sel_pad[w*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/xl_intc_chk.sv
// Module: assertion checker bound into xl_intc; watches ports and the
// control state to confirm gating, alias and latch rules.
// Assumes NUM_LINES >= 1; word-0 checks cover the first min(32, N) lines.
module xl_intc_chk
    import xl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [NUM_LINES-1:0] line_status_o,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] dom_q,
    input logic [NUM_LINES-1:0] soft_q,
    input logic [NUM_LINES-1:0] latch_q
);
    localparam int LW = (NUM_LINES < DATA_W) ? NUM_LINES : DATA_W;
    localparam logic [ADDR_W-1:0] A_MSET = {WIN_MASK_SET, 6'd0};
    localparam logic [ADDR_W-1:0] A_ACK  = {WIN_ACK, 6'd0};

    logic unused_chk;
    assign unused_chk = ^{bus_wdata, mask_q, latch_q};

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (line_status_o == '0)); // R1

    AST_MASK_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MSET) |=>
        ((mask_q[LW-1:0] & $past(bus_wdata[LW-1:0])) == $past(bus_wdata[LW-1:0]))); // R2

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_status_o & mask_q) == '0)); // R3

    AST_LATCH_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_ACK) |=>
        (($past(latch_q[LW-1:0]) & ~latch_q[LW-1:0]) == '0)); // R6

    AST_SOFT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_q & ~mask_q & dom_q & ~line_status_o) == '0)); // R8

    AST_DOMAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_status_o & ~dom_q) == '0)); // R9
endmodule

bind xl_intc xl_intc_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .line_status_o(line_status_o), .mask_q(mask_q),
    .dom_q(dom_q), .soft_q(soft_q), .latch_q(latch_q)
);

// File: tb/tb_xl_intc.sv
module tb_xl_intc;
    localparam int CLK_PERIOD = 10;
    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin = '0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  status;
    logic          irq;
    int            checks = 0;
    int            fails = 0;

    xl_intc #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_status_o(status), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register-write then read-back vectors: {waddr, wdata, raddr, expected}.
    localparam logic [87:0] VEC [12] = '{
        {12'h100, 32'h0000000F, 12'h080, 32'hFFFFFFF0},  // R2 mask clear
        {12'h0C0, 32'h00000001, 12'h080, 32'hFFFFFFF1},  // R2 mask set
        {12'h080, 32'h00000000, 12'h080, 32'hFFFFFFF1},  // R2 view ignored
        {12'h180, 32'h000000A0, 12'h140, 32'h000000A0},  // R2 sens set
        {12'h1C0, 32'h00000020, 12'h140, 32'h00000080},  // R2 sens clear
        {12'h344, 32'h00000003, 12'h304, 32'h00000003},  // R11 pol set word1
        {12'h384, 32'h00000001, 12'h304, 32'h00000002},  // R11 pol clear word1
        {12'h140, 32'h0000FFFF, 12'h140, 32'h00000080},  // R2 view ignored
        {12'h344, 32'hFFFFFF00, 12'h304, 32'h00000002},  // R2 dead bits
        {12'h400, 32'h0000FFFF, 12'h400, 32'h0000FFFF},  // R2 domain direct
        {12'h104, 32'hFFFFFFFF, 12'h084, 32'h00000000},  // R11 unmask word1
        {12'h0C4, 32'hFFFFFFFF, 12'h084, 32'h000000FF}   // R11 remask word1
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic reset_dut();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state();
        rd(12'h080, 32'hFFFFFFFF, "R1 mask w0");
        rd(12'h084, 32'h000000FF, "R1 mask w1");
        rd(12'h140, 32'h0, "R1 sens");
        rd(12'h304, 32'h0, "R1 pol w1");
        rd(12'h200, 32'h0, "R1 soft");
        rd(12'h400, 32'h0, "R1 dom");
        rd(12'h000, 32'h0, "R1 status");
        chk({31'b0, irq}, 32'h0, "R1 irq");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        reset_dut();
        check_reset_state();

        for (int v = 0; v < 12; v++) begin
            wr(VEC[v][87:76], VEC[v][75:44]);
            rd(VEC[v][43:32], VEC[v][31:0], $sformatf("R2 vector %0d", v));
        end

        // Back to a clean, domain-enabled configuration.
        wr(12'h1C0, 32'hFFFFFFFF); wr(12'h380, 32'hFFFFFFFF); wr(12'h384, 32'hFFFFFFFF);
        wr(12'h0C0, 32'hFFFFFFFF); wr(12'h400, 32'hFFFFFFFF); wr(12'h404, 32'hFFFFFFFF);
        wr(12'h040, 32'hFFFFFFFF); wr(12'h044, 32'hFFFFFFFF);
        rd(12'h000, 32'h0, "R10 status clean");

        // R4 rising edge on line 3, with latency.
        wr(12'h340, 32'h8); wr(12'h100, 32'h28);
        @(negedge clk); pin[3] = 1'b1;
        idle(2);
        chk({31'b0, status[3]}, 32'h0, "R4 not yet after two edges");
        idle(1);
        chk({31'b0, status[3]}, 32'h1, "R4 rising latched");
        chk({31'b0, irq}, 32'h1, "R10 irq high");
        pin[3] = 1'b0; idle(4);
        rd(12'h000, 32'h8, "R4 latch holds after pin drops");

        // R4 falling edge on line 5 (polarity 0).
        pin[5] = 1'b1; idle(4);
        rd(12'h000, 32'h8, "R4 rise ignored for falling polarity");
        pin[5] = 1'b0; idle(4);
        rd(12'h000, 32'h28, "R4 falling latched");

        // R6 acknowledge only the written line.
        wr(12'h040, 32'h8);
        rd(12'h000, 32'h20, "R6 ack clears only line 3");
        wr(12'h040, 32'h20);
        rd(12'h000, 32'h0, "R6 ack line 5");
        chk({31'b0, irq}, 32'h0, "R10 irq low");

        // R7 acknowledge in the same cycle as a new edge.
        @(negedge clk); pin[3] = 1'b1;
        idle(2);
        bus_addr = 12'h040; bus_wdata = 32'h8; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(12'h000, 32'h8, "R7 edge wins over ack");
        pin[3] = 1'b0; idle(4);
        wr(12'h040, 32'h8);
        rd(12'h000, 32'h0, "R7 later ack clears");

        // R5 and R11 level-low on line 33 (word 1 bit 1).
        wr(12'h184, 32'h2); wr(12'h104, 32'h2);
        rd(12'h004, 32'h2, "R5 level active low");
        pin[33] = 1'b1; idle(3);
        rd(12'h004, 32'h0, "R5 level released, no latch");
        pin[33] = 1'b0; idle(3);
        rd(12'h004, 32'h2, "R11 word1 level again");
        wr(12'h0C4, 32'h2);
        rd(12'h004, 32'h0, "R3 mask hides level");

        // R8 software trigger on line 7, and mask over it.
        wr(12'h100, 32'h80); wr(12'h240, 32'h80);
        rd(12'h000, 32'h80, "R8 soft pending");
        idle(5);
        rd(12'h200, 32'h80, "R8 soft bit persists");
        wr(12'h0C0, 32'h80);
        rd(12'h000, 32'h0, "R3 mask hides soft");
        wr(12'h100, 32'h80);
        rd(12'h000, 32'h80, "R3 unmask restores soft");
        wr(12'h280, 32'h80);
        rd(12'h000, 32'h0, "R8 soft clear");

        // R9 domain disable on line 9.
        wr(12'h100, 32'h200); wr(12'h400, 32'hFFFFFDFF); wr(12'h240, 32'h200);
        rd(12'h000, 32'h0, "R9 domain off hides soft");
        chk({31'b0, irq}, 32'h0, "R9 irq stays low");
        wr(12'h400, 32'hFFFFFFFF);
        rd(12'h000, 32'h200, "R9 domain on shows soft");
        wr(12'h280, 32'h200);

        // R2 misaligned write ignored.
        wr(12'h241, 32'h1);
        rd(12'h200, 32'h0, "R2 misaligned ignored");

        // R1 reset after activity.
        wr(12'h240, 32'h1); wr(12'h100, 32'h1);
        reset_dut();
        check_reset_state();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule